// File: doc/BRIEF.md
# Serial EEPROM Target with Page Write Buffer

This block is a two-wire serial bus target that behaves like a small 128-byte EEPROM. It watches the clock and data lines as oversampled inputs. It decodes a device address, takes a word address and then accepts data bytes into a 16-entry page buffer. When the write ends with STOP, the buffer is committed to the internal array in one step. A timed programming cycle follows. During that cycle the block refuses to acknowledge its own address, so a host can poll until the part is free.

Reads return array bytes most significant bit first from an internal pointer. The pointer moves on across the whole array each time the host acknowledges a byte. A write that carries only a word address and is followed by a repeated START gives a random read. The block drives the data line only through an open-drain pull-down enable. There is no streaming handshake at the block's edge: the two bus lines carry all traffic, and the host gets its back-pressure from the acknowledge bit alone.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A device address byte whose top four bits are 1010 is acknowledged whatever its bits 3..1 hold. Bit 0 selects read (1) or write (0). Any other top nibble is not acknowledged, and the rest of that transfer is ignored.
- R2: In a write transfer, the first byte after the device address is acknowledged, and its low 7 bits load the word pointer.
- R3: Every data byte of a write is acknowledged on the ninth clock. The byte goes to the buffer slot picked by pointer bits 3..0. Only those four bits then step by one, and pointer bits 6..4 stay fixed.
- R4: When more than 16 data bytes arrive before STOP, the slot index rolls over within the page, and the later bytes replace the earlier ones held at the same slots.
- R5: A STOP after at least one data byte commits all received bytes to their page in a single clock. The page bytes that were not received keep their old contents.
- R6: After a commit, `busy` is high for exactly TWR_CYCLES consecutive clocks. It is low out of reset.
- R7: While `busy` is high, a START followed by a matching device address gets no acknowledge. Once `busy` has fallen, the same address is acknowledged.
- R8: A write that ends with a repeated START, or that has no data byte before STOP, starts no programming cycle and changes no array byte. Only the pointer is updated.
- R9: A read returns the byte at the pointer, MSB first. Each host acknowledge advances the pointer by one modulo 128 (0x7F is followed by 0x00). A host NACK leaves the pointer where it is and ends the read.
- R10: `sda_oe` is low after reset and changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | When high, pull the data line low |
| busy | output | 1 | Internal programming cycle in progress |

## Verification
A single-byte write followed at once by an address poll separates the busy refusal from a normal acknowledge. The same poll repeated once `busy` has dropped confirms recovery. A six-byte page write that starts at slot 12 shows the in-page rollover, and reading back the whole page shows which untouched slots kept zero. A twenty-byte write shows that earlier bytes are overwritten. A write that stops after only a word address, and one that is cut short by a repeated START, prove that no programming cycle starts. Random, current-address and wrap-around sequential reads tell pointer advance on acknowledge apart from a hold on NACK.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_MACK
  } bus_st_e;

  localparam logic [3:0] DEV_TAG = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // data edges while the clock stays high mark bus conditions
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic                              we,
  input  logic [PAGE_W-1:0]                 widx,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [(1<<PAGE_W)-1:0][DATA_W-1:0] pg_data,
  output logic [(1<<PAGE_W)-1:0]            pg_valid
);
  localparam int DEPTH = 1 << PAGE_W;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pg_data[g]  <= '0;
        pg_valid[g] <= 1'b0;
      end else if (clr) begin
        pg_valid[g] <= 1'b0;
      end else if (we && widx == PAGE_W'(g)) begin
        pg_data[g]  <= wdata;
        pg_valid[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W     = 7,
  parameter int PAGE_W     = 4,
  parameter int DATA_W     = 8,
  parameter int TWR_CYCLES = 600
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit,
  input  logic [ADDR_W-PAGE_W-1:0]          commit_page,
  input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0] pg_data,
  input  logic [(1<<PAGE_W)-1:0]            pg_valid,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_data,
  output logic                              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;
  localparam int CNT_W = $clog2(TWR_CYCLES + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  twr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (commit) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (pg_valid[i]) mem[{commit_page, PAGE_W'(i)}] <= pg_data[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              twr_cnt <= '0;
    else if (commit)         twr_cnt <= CNT_W'(TWR_CYCLES);
    else if (twr_cnt != '0)  twr_cnt <= twr_cnt - CNT_W'(1);
  end

  assign busy    = (twr_cnt != '0);
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int PAGE_W      = 4,
  parameter int TWR_CYCLES  = 600,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic busy
);
  localparam int DATA_W = 8;
  localparam int SLOTS  = 1 << PAGE_W;
  localparam int PG_W   = ADDR_W - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  bus_st_e st, nxt;
  logic [3:0]        bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic [ADDR_W-1:0] ptr;
  logic              got_data, mack_ok, commit;
  logic              buf_clr, buf_we;
  logic [PAGE_W-1:0] buf_idx;
  logic [DATA_W-1:0] buf_wdata, rd_data;
  logic [SLOTS-1:0][DATA_W-1:0] pg_data;
  logic [SLOTS-1:0]  pg_valid;
  logic [PG_W-1:0]   commit_page;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eeprom_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .widx(buf_idx),
    .wdata(buf_wdata), .pg_data(pg_data), .pg_valid(pg_valid)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                 .TWR_CYCLES(TWR_CYCLES)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_page(commit_page),
    .pg_data(pg_data), .pg_valid(pg_valid), .rd_addr(ptr), .rd_data(rd_data),
    .busy(busy)
  );

  // page bits never move during a write, so the pointer names the page at STOP
  assign commit_page = ptr[ADDR_W-1:PAGE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      nxt       <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      ptr       <= '0;
      got_data  <= 1'b0;
      mack_ok   <= 1'b0;
      commit    <= 1'b0;
      buf_clr   <= 1'b0;
      buf_we    <= 1'b0;
      buf_idx   <= '0;
      buf_wdata <= '0;
      sda_oe    <= 1'b0;
    end else begin
      commit  <= 1'b0;
      buf_clr <= 1'b0;
      buf_we  <= 1'b0;
      if (start_det) begin
        // a repeated START throws away anything buffered so far
        st       <= ST_DEV;
        bit_cnt  <= '0;
        sda_oe   <= 1'b0;
        got_data <= 1'b0;
        buf_clr  <= 1'b1;
      end else if (stop_det) begin
        if (got_data) commit <= 1'b1;
        got_data <= 1'b0;
        st       <= ST_IDLE;
        sda_oe   <= 1'b0;
      end else begin
        unique case (st)
          ST_DEV, ST_WADR, ST_WDAT: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[DATA_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (st == ST_DEV) begin
                if (shreg[7:4] == DEV_TAG && !busy) begin
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                  nxt    <= shreg[0] ? ST_RDAT : ST_WADR;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_WADR) begin
                sda_oe <= 1'b1;
                ptr    <= shreg[ADDR_W-1:0];
                st     <= ST_ACK;
                nxt    <= ST_WDAT;
              end else begin
                sda_oe    <= 1'b1;
                buf_we    <= 1'b1;
                buf_idx   <= ptr[PAGE_W-1:0];
                buf_wdata <= shreg;
                ptr       <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
                got_data  <= 1'b1;
                st        <= ST_ACK;
                nxt       <= ST_WDAT;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              st      <= nxt;
              if (nxt == ST_RDAT) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[DATA_W-1];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= ST_MACK;
              end else begin
                sda_oe <= ~shreg[DATA_W-2];
                shreg  <= {shreg[DATA_W-2:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_s;
              if (!sda_s) ptr <= ptr + ADDR_W'(1);
            end else if (scl_fall) begin
              if (mack_ok) begin
                shreg   <= rd_data;
                sda_oe  <= ~rd_data[DATA_W-1];
                bit_cnt <= '0;
                st      <= ST_RDAT;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_chk.sv
module i2c_eeprom_chk
  import eeprom_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int PAGE_W     = 4,
  parameter int TWR_CYCLES = 600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              scl_fall,
  input logic              commit,
  input bus_st_e           st,
  input logic [3:0]        bit_cnt,
  input logic [ADDR_W-1:0] ptr
);
  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 32'd1;
    else           run_len <= '0;
  end

  // R6
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < 32'(TWR_CYCLES));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && run_len != '0) |-> run_len == 32'(TWR_CYCLES));

  // R5
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy);

  // R5
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  // R7
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEV && bit_cnt == 4'd8 && scl_fall && busy) |=> !sda_oe);

  // R3
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WDAT) |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
endmodule

bind i2c_eeprom_target i2c_eeprom_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TWR_CYCLES(TWR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sda_oe(sda_oe), .scl_s(scl_s),
  .scl_fall(scl_fall), .commit(commit), .st(st), .bit_cnt(bit_cnt), .ptr(ptr)
);

// File: tb/i2c_eeprom_target_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_target_tb;
  localparam int TWR = 600;
  localparam int Q   = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy, sda_line;
  assign sda_line = sda_m & ~sda_oe;
  always #2.5 clk = ~clk;

  i2c_eeprom_target #(.TWR_CYCLES(TWR)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .busy(busy)
  );

  int errors = 0, checks = 0;
  logic [7:0] model [128];
  logic [7:0] wbuf [32];
  int mptr = 0;
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string tag_q [$];
  int busy_run = 0, last_run = 0, busy_rises = 0, oe_viol = 0, exp_rises = 0;
  logic busy_d = 1'b0, oe_d = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    busy_d <= busy;
    oe_d   <= sda_oe;
    if (rst_n && sda_oe != oe_d && scl) oe_viol <= oe_viol + 1;
    if (busy) busy_run <= busy_run + 1;
    else begin
      if (busy_d) last_run <= busy_run;
      busy_run <= 0;
    end
    if (busy && !busy_d) busy_rises <= busy_rises + 1;
  end

  // scoreboard monitor
  always @(negedge clk) begin : mon
    logic [7:0] a, e;
    string t;
    if (act_q.size() > 0 && exp_q.size() > 0) begin
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(a == e, t, a, e);
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl = 1'b1; wait_q(); sda_m = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(); scl = 1'b1; wait_q(); wait_q(); scl = 1'b0; wait_q();
    end
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
    ack = ~sda_line;
    wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q(); scl = 1'b1; wait_q();
      b[i] = sda_line;
      wait_q(); scl = 1'b0; wait_q();
    end
    sda_m = ~mack; wait_q(); scl = 1'b1; wait_q(); wait_q(); scl = 1'b0; wait_q();
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // write: device 0xA0, word address, n data bytes; model only changes on STOP with data
  task automatic write_tx(input logic [6:0] addr, input int n, input bit stop);
    bit ack;
    int off;
    send_dev(8'hA0, "R1 write address ack");
    send_byte({1'b0, addr}, ack);
    chk(ack, "R2 word address ack", ack, 1);
    off = addr[3:0];
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk(ack, "R3 data byte ack", ack, 1);
      if (stop) model[{addr[6:4], 4'(off)}] = wbuf[i];
      off = (off + 1) & 15;
    end
    mptr = {addr[6:4], 4'(off)};
    if (stop) begin
      bus_stop();
      if (n > 0) exp_rises++;
    end
  endtask

  task automatic send_dev(input logic [7:0] dev, input string tag);
    bit ack;
    bus_start();
    send_byte(dev, ack);
    chk(ack, tag, ack, 1);
  endtask

  task automatic cur_read(input int n, input string tag);
    logic [7:0] b;
    send_dev(8'hA1, "R1 read address ack");
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[mptr]);
      tag_q.push_back(tag);
      recv_byte(i < n - 1, b);
      act_q.push_back(b);
      if (i < n - 1) mptr = (mptr + 1) % 128;
    end
    bus_stop();
  endtask

  task automatic read_tx(input logic [6:0] addr, input int n, input string tag);
    wait_idle();
    write_tx(addr, 0, 1'b0);
    cur_read(n, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ack;
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 released after reset", sda_oe, 0);
    chk(busy == 1'b0, "R6 idle after reset", busy, 0);

    // R1 foreign device address ignored
    bus_start();
    send_byte(8'hB0, ack);
    chk(!ack, "R1 foreign address nack", ack, 0);
    bus_stop();
    repeat (20) @(negedge clk);
    chk(busy_rises == 0, "R1 foreign transfer no program", busy_rises, 0);

    // byte write, then poll while busy (R7) and measure cycle length (R6)
    wbuf[0] = 8'hA5;
    write_tx(7'h05, 1, 1'b1);
    bus_start();
    send_byte(8'hA0, ack);
    chk(!ack, "R7 no ack while busy", ack, 0);
    bus_stop();
    wait_idle();
    chk(last_run == TWR, "R6 busy length", last_run, TWR);
    bus_start();
    send_byte(8'hA0, ack);
    chk(ack, "R7 ack after busy", ack, 1);
    bus_stop();
    repeat (40) @(negedge clk);
    chk(busy_rises == exp_rises, "R8 no program without data", busy_rises, exp_rises);

    // random read then current-address read: NACK must not advance (R9)
    read_tx(7'h05, 1, "R9 random read");
    cur_read(1, "R9 nack holds pointer");

    // page write starting at slot 12, wraps to slots 0,1 (R3, R5)
    wait_idle();
    for (int i = 0; i < 6; i++) wbuf[i] = 8'h61 + 8'(i);
    write_tx(7'h1C, 6, 1'b1);
    read_tx(7'h10, 16, "R3 R5 page rollover and untouched slots");

    // 20 bytes into one page: first four replaced (R4)
    wait_idle();
    for (int i = 0; i < 20; i++) wbuf[i] = 8'h40 + 8'(i);
    write_tx(7'h20, 20, 1'b1);
    read_tx(7'h20, 16, "R4 overwrite on overflow");

    // data then repeated START: discarded, pointer only (R8)
    wait_idle();
    wbuf[0] = 8'h11;
    write_tx(7'h30, 1, 1'b0);
    write_tx(7'h40, 0, 1'b0);
    cur_read(1, "R8 pointer after address-only write");
    repeat (20) @(negedge clk);
    chk(busy_rises == exp_rises, "R8 repeated start no program", busy_rises, exp_rises);
    read_tx(7'h30, 1, "R8 discarded byte not written");

    // don't-care bits in device address (R1)
    send_dev(8'hAE, "R1 dont-care bits ack");
    bus_stop();

    // sequential read across top of array (R9)
    wait_idle();
    wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
    write_tx(7'h7E, 2, 1'b1);
    read_tx(7'h7E, 4, "R9 pointer wraps 7F to 00");

    repeat (20) @(negedge clk);
    chk(busy_rises == exp_rises, "R5 one cycle per commit", busy_rises, exp_rises);
    chk(oe_viol == 0, "R10 sda_oe only moves with scl low", oe_viol, 0);
    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule